// File: doc/BRIEF.md
# Single-Register Load/Store Execution Unit

This unit carries out one single-register memory transfer for a 32-bit core in which register 15 holds the program counter. That register also holds the status flags and the mode bits. Each instruction arrives as a decoded word together with a shifted-register offset produced elsewhere. The unit reads the base and data registers from the register file, forms the transfer address by pre- or post-indexing, issues one byte or word request on a valid/ready memory port, and waits for the response. It then presents the register writes and the transfer's cycle cost in a single `done` cycle.

Register 15 needs special handling in several places. As a base, only its address field is used, with a pipeline correction of +8 in some modes. As a store source, it is written as R15+8. As a load destination, only its address field is replaced. When the loaded register is also the base, the loaded value wins over the base update.

Top module: `ldst_unit`

Instruction fields: Rn in bits 19:16, Rd in bits 15:12, a 12-bit immediate in bits 11:0. The single-bit controls are L (load) at bit 20, W (writeback) at bit 21, B (byte) at bit 22, U (add) at bit 23, P (pre-index) at bit 24 and I (register offset) at bit 25. The address mask for R15 is 0x03FFFFFC.

## Requirements
- R1: After reset, `idle` is 1 and `mem_req_valid`, `done`, `wb_data_en` and `wb_base_en` are 0. Register writes appear only in the `done` cycle.
- R2: The offset is the zero-extended bits 11:0 of the instruction when I (bit 20+5=25) is 0, and `shifted_off` when I is 1.
- R3: With P=1, the address is base+offset when U=1 and base−offset when U=0. When Rn is 15, the base is R15 AND 0x03FFFFFC.
- R4: With P=1 and W=1, the computed address is written to Rn. With P=1, W=0 and Rn=15, the transfer address is the computed value plus 8, and no base write occurs.
- R5: With P=0, the transfer uses the unmodified base, or (R15 AND 0x03FFFFFC)+8 when Rn is 15. Rn is then written with the address plus the offset (U=1) or minus the offset (U=0).
- R6: When Rd equals Rn, the base write is dropped for every load and for every post-indexed store. A load still writes Rd.
- R7: A byte load (B=1, L=1) writes `mem_rdata[7:0]` zero-extended. A byte store drives `mem_byte`=1 and `mem_wdata` = {24'b0, Rd[7:0]}.
- R8: A word store whose source Rd is 15 drives `mem_wdata` = R15 + 8.
- R9: A word load into Rd=15 writes (rdata AND 0x03FFFFFC) OR (old R15 AND NOT 0x03FFFFFC). It subtracts 4 from that value when rdata[1:0] is 0.
- R10: At `done`, the cost is S=1, I=1, N=1 for a load. A word load into R15 costs S=2, I=1, N=2. A store costs S=0, I=0, N=2.
- R11: `mem_req_valid` stays high with a stable address until `mem_req_ready`. `done` is high for exactly one cycle, the cycle after the one in which `mem_rsp_valid` is seen.
- R12: `start` is ignored while the unit is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| instr | input | 32 | Decoded instruction word |
| shifted_off | input | 32 | Shifted-register offset used when I=1 |
| idle | output | 1 | Unit can accept an instruction |
| rf_ra_idx | output | 4 | Register file read index for the base (Rn) |
| rf_ra_data | input | 32 | Base register value |
| rf_rb_idx | output | 4 | Register file read index for the data register (Rd) |
| rf_rb_data | input | 32 | Data register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_addr | output | 32 | Transfer address |
| mem_we | output | 1 | 1 for store |
| mem_byte | output | 1 | 1 for byte transfer |
| mem_wdata | output | 32 | Store data |
| mem_rsp_valid | input | 1 | Memory response (load data or store completion) |
| mem_rdata | input | 32 | Load data, byte in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| wb_data_en | output | 1 | Write loaded value to Rd |
| wb_data_idx | output | 4 | Rd index |
| wb_data_val | output | 32 | Loaded value |
| wb_base_en | output | 1 | Write updated base to Rn |
| wb_base_idx | output | 4 | Rn index |
| wb_base_val | output | 32 | Updated base |
| cost_s | output | 3 | Sequential cycle count |
| cost_i | output | 3 | Internal cycle count |
| cost_n | output | 3 | Non-sequential cycle count |

## Verification
The hardest situation to reach is a second `start` that arrives while a request is stalled. It must change neither the address held on the port nor the final register writes. The bench holds `mem_req_ready` low for several cycles and pulses `start` with a different store instruction during the stall. It then checks that the original load's address, direction and write-back came through. The bench also covers the R15 cases, with a register-15 value that mixes flag bits, address bits and mode bits, so that masking, +8 and −4 errors show up in the expected words.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int XLEN     = 32;
    localparam int RIDX_W   = 4;
    localparam int IMM_W    = 12;
    localparam int COST_W   = 3;
    localparam logic [RIDX_W-1:0] PC_IDX = 4'd15;
    localparam logic [XLEN-1:0]   ADDR_MASK = 32'h03FF_FFFC;
    localparam logic [XLEN-1:0]   PIPE_AHEAD = 32'd8;
    localparam logic [XLEN-1:0]   PIPE_BACK  = 32'd4;

    localparam int BIT_L = 20;
    localparam int BIT_W = 21;
    localparam int BIT_B = 22;
    localparam int BIT_U = 23;
    localparam int BIT_P = 24;
    localparam int BIT_I = 25;
    localparam int RN_LO = 16;
    localparam int RD_LO = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } ldst_state_e;

    typedef struct packed {
        ldst_state_e       state;
        logic              is_load;
        logic              is_byte;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rn;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   wdata;
        logic [XLEN-1:0]   old_rd;
        logic [XLEN-1:0]   base_next;
        logic              base_we;
        logic [XLEN-1:0]   ld_val;
    } ldst_regs_t;
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
    import ldst_pkg::*;
(
    input  logic              pre_idx,
    input  logic              add_off,
    input  logic              wback,
    input  logic              reg_off,
    input  logic [RIDX_W-1:0] rn,
    input  logic [IMM_W-1:0]  imm,
    input  logic [XLEN-1:0]   shifted_off,
    input  logic [XLEN-1:0]   base_raw,
    output logic [XLEN-1:0]   xfer_addr,
    output logic [XLEN-1:0]   base_next,
    output logic              base_we
);
    logic            base_is_pc;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] off;
    logic [XLEN-1:0] indexed;

    always_comb begin
        base_is_pc = (rn == PC_IDX);
        base       = base_is_pc ? (base_raw & ADDR_MASK) : base_raw;
        off        = reg_off ? shifted_off : {{(XLEN-IMM_W){1'b0}}, imm};
        indexed    = add_off ? (base + off) : (base - off);
        if (pre_idx) begin
            xfer_addr = (!wback && base_is_pc) ? (indexed + PIPE_AHEAD) : indexed;
            base_next = indexed;
            base_we   = wback;
        end else begin
            xfer_addr = base_is_pc ? (base + PIPE_AHEAD) : base;
            base_next = add_off ? (xfer_addr + off) : (xfer_addr - off);
            base_we   = 1'b1;
        end
    end
endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
    import ldst_pkg::*;
(
    input  logic            is_byte,
    input  logic            rd_is_pc,
    input  logic [XLEN-1:0] rdata,
    input  logic [XLEN-1:0] old_pc,
    output logic [XLEN-1:0] value
);
    logic [XLEN-1:0] merged;

    always_comb begin
        merged = (rdata & ADDR_MASK) | (old_pc & ~ADDR_MASK);
        if (rdata[1:0] == 2'b00) begin
            merged = merged - PIPE_BACK;
        end
        if (is_byte) begin
            value = {{(XLEN-8){1'b0}}, rdata[7:0]};
        end else if (rd_is_pc) begin
            value = merged;
        end else begin
            value = rdata;
        end
    end
endmodule

// File: rtl/ldst_cost.sv
module ldst_cost
    import ldst_pkg::*;
(
    input  logic              is_load,
    input  logic              is_byte,
    input  logic              rd_is_pc,
    output logic [COST_W-1:0] cost_s,
    output logic [COST_W-1:0] cost_i,
    output logic [COST_W-1:0] cost_n
);
    logic pc_extra;

    always_comb begin
        pc_extra = is_load && !is_byte && rd_is_pc;
        if (is_load) begin
            cost_s = pc_extra ? COST_W'(2) : COST_W'(1);
            cost_i = COST_W'(1);
            cost_n = pc_extra ? COST_W'(2) : COST_W'(1);
        end else begin
            cost_s = '0;
            cost_i = '0;
            cost_n = COST_W'(2);
        end
    end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   shifted_off,
    output logic              idle,
    output logic [RIDX_W-1:0] rf_ra_idx,
    input  logic [XLEN-1:0]   rf_ra_data,
    output logic [RIDX_W-1:0] rf_rb_idx,
    input  logic [XLEN-1:0]   rf_rb_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    output logic              wb_data_en,
    output logic [RIDX_W-1:0] wb_data_idx,
    output logic [XLEN-1:0]   wb_data_val,
    output logic              wb_base_en,
    output logic [RIDX_W-1:0] wb_base_idx,
    output logic [XLEN-1:0]   wb_base_val,
    output logic [COST_W-1:0] cost_s,
    output logic [COST_W-1:0] cost_i,
    output logic [COST_W-1:0] cost_n
);
    ldst_regs_t r_d, r_q;

    logic [RIDX_W-1:0] in_rn, in_rd;
    logic              in_load, in_byte, in_pre;
    logic [XLEN-1:0]   ag_addr, ag_base_next;
    logic              ag_base_we;
    logic [XLEN-1:0]   fmt_val;
    logic              unused_hi;

    assign in_rn     = instr[RN_LO +: RIDX_W];
    assign in_rd     = instr[RD_LO +: RIDX_W];
    assign in_load   = instr[BIT_L];
    assign in_byte   = instr[BIT_B];
    assign in_pre    = instr[BIT_P];
    assign unused_hi = ^instr[XLEN-1:BIT_I+1];
    assign rf_ra_idx = in_rn;
    assign rf_rb_idx = in_rd;

    ldst_addr_gen u_agen (
        .pre_idx     (in_pre),
        .add_off     (instr[BIT_U]),
        .wback       (instr[BIT_W]),
        .reg_off     (instr[BIT_I]),
        .rn          (in_rn),
        .imm         (instr[IMM_W-1:0]),
        .shifted_off (shifted_off),
        .base_raw    (rf_ra_data),
        .xfer_addr   (ag_addr),
        .base_next   (ag_base_next),
        .base_we     (ag_base_we)
    );

    ldst_load_fmt u_fmt (
        .is_byte  (r_q.is_byte),
        .rd_is_pc (r_q.rd == PC_IDX),
        .rdata    (mem_rdata),
        .old_pc   (r_q.old_rd),
        .value    (fmt_val)
    );

    ldst_cost u_cost (
        .is_load  (r_q.is_load),
        .is_byte  (r_q.is_byte),
        .rd_is_pc (r_q.rd == PC_IDX),
        .cost_s   (cost_s),
        .cost_i   (cost_i),
        .cost_n   (cost_n)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state     = ST_REQ;
                    r_d.is_load   = in_load;
                    r_d.is_byte   = in_byte;
                    r_d.rd        = in_rd;
                    r_d.rn        = in_rn;
                    r_d.addr      = ag_addr;
                    r_d.old_rd    = rf_rb_data;
                    r_d.base_next = ag_base_next;
                    r_d.base_we   = ag_base_we &&
                                    !((in_rd == in_rn) && (in_load || !in_pre));
                    if (in_byte) begin
                        r_d.wdata = {{(XLEN-8){1'b0}}, rf_rb_data[7:0]};
                    end else if (in_rd == PC_IDX) begin
                        r_d.wdata = rf_rb_data + PIPE_AHEAD;
                    end else begin
                        r_d.wdata = rf_rb_data;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    r_d.state = ST_RSP;
                end
            end
            ST_RSP: begin
                if (mem_rsp_valid) begin
                    r_d.state  = ST_DONE;
                    r_d.ld_val = fmt_val;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle          = (r_q.state == ST_IDLE);
    assign mem_req_valid = (r_q.state == ST_REQ);
    assign mem_addr      = r_q.addr;
    assign mem_we        = !r_q.is_load;
    assign mem_byte      = r_q.is_byte;
    assign mem_wdata     = r_q.wdata;
    assign done          = (r_q.state == ST_DONE);
    assign wb_data_en    = done && r_q.is_load;
    assign wb_data_idx   = r_q.rd;
    assign wb_data_val   = r_q.ld_val;
    assign wb_base_en    = done && r_q.base_we;
    assign wb_base_idx   = r_q.rn;
    assign wb_base_val   = r_q.base_next;
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk
    import ldst_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              idle,
    input logic              done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic              mem_rsp_valid,
    input logic              mem_we,
    input logic              mem_byte,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              wb_data_en,
    input logic [RIDX_W-1:0] wb_data_idx,
    input logic              wb_base_en,
    input logic [RIDX_W-1:0] wb_base_idx,
    input logic [COST_W-1:0] cost_n
);
    p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req_valid);

    p_write_only_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_data_en || wb_base_en) |-> done);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid));

    p_no_dual_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_data_en && wb_base_en) |-> (wb_data_idx != wb_base_idx));

    p_byte_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_we && mem_byte) |-> (mem_wdata[XLEN-1:8] == '0));

    p_cost_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cost_n != '0));
endmodule

bind ldst_unit ldst_unit_chk u_chk (.*);

// File: tb/ldst_unit_tb_top.sv
module ldst_unit_tb_top;
    import ldst_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              start = 1'b0;
    logic [31:0]       instr = '0;
    logic [31:0]       shifted_off = '0;
    logic              idle;
    logic [3:0]        rf_ra_idx, rf_rb_idx;
    logic [31:0]       rf_ra_data, rf_rb_data;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [31:0]       mem_addr;
    logic              mem_we, mem_byte;
    logic [31:0]       mem_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              done;
    logic              wb_data_en, wb_base_en;
    logic [3:0]        wb_data_idx, wb_base_idx;
    logic [31:0]       wb_data_val, wb_base_val;
    logic [2:0]        cost_s, cost_i, cost_n;

    logic [31:0] regs [16];
    assign rf_ra_data = regs[rf_ra_idx];
    assign rf_rb_data = regs[rf_rb_idx];

    ldst_unit dut_i (.*);

    int n_tests = 0;
    int n_fail  = 0;

    // captured results of one operation
    logic [31:0] c_addr, c_addr0, c_wdata, c_dval, c_bval;
    logic        c_we, c_byte, c_valid_held, c_done, c_done_after, c_den, c_ben;
    logic [3:0]  c_didx, c_bidx;
    logic [2:0]  c_s, c_i, c_n;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit p, input bit u, input bit b, input bit w,
                                       input bit l, input bit i, input int rn, input int rd,
                                       input logic [11:0] imm);
        logic [31:0] v;
        v = 32'hE400_0000;
        v[BIT_I] = i; v[BIT_P] = p; v[BIT_U] = u; v[BIT_B] = b; v[BIT_W] = w; v[BIT_L] = l;
        v[19:16] = rn[3:0]; v[15:12] = rd[3:0]; v[11:0] = imm;
        return v;
    endfunction

    task automatic run_op(input logic [31:0] ins, input logic [31:0] so,
                          input logic [31:0] rdv, input int dly, input bit poke);
        @(negedge clk);
        start = 1'b1; instr = ins; shifted_off = so;
        @(negedge clk);
        start = 1'b0;
        c_addr0 = mem_addr;
        c_valid_held = mem_req_valid;
        for (int k = 0; k < dly; k++) begin
            if (poke && k == 0) begin
                start = 1'b1; instr = mk(1, 0, 0, 1, 0, 0, 9, 8, 12'h444);
                shifted_off = 32'h10;
            end
            @(negedge clk);
            start = 1'b0;
            c_valid_held = c_valid_held && mem_req_valid;
        end
        c_addr = mem_addr; c_we = mem_we; c_byte = mem_byte; c_wdata = mem_wdata;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rdata = rdv;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        c_done = done; c_den = wb_data_en; c_didx = wb_data_idx; c_dval = wb_data_val;
        c_ben = wb_base_en; c_bidx = wb_base_idx; c_bval = wb_base_val;
        c_s = cost_s; c_i = cost_i; c_n = cost_n;
        @(negedge clk);
        c_done_after = done;
    endtask

    task automatic t_reset;
        chk("R1 idle", 32'(idle), 1);
        chk("R1 req_valid", 32'(mem_req_valid), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 writes", 32'({wb_data_en, wb_base_en}), 0);
    endtask

    task automatic t_pre_imm_load;
        run_op(mk(1, 1, 0, 0, 1, 0, 2, 3, 12'h0A4), 32'hDEAD, 32'h1234_5678, 0, 0);
        chk("R2 R3 addr imm add", c_addr, regs[2] + 32'h0A4);
        chk("R3 load data", c_dval, 32'h1234_5678);
        chk("R3 data en/idx", {27'd0, c_den, c_didx}, {27'd0, 1'b1, 4'd3});
        chk("R4 no base write W=0", 32'(c_ben), 0);
        chk("R11 done pulse", {30'd0, c_done, c_done_after}, 32'b10);
        chk("R10 load cost", {23'd0, c_s, c_i, c_n}, {23'd0, 3'd1, 3'd1, 3'd1});
    endtask

    task automatic t_pre_reg_store_wb;
        run_op(mk(1, 0, 0, 1, 0, 1, 4, 6, 12'h0FF), 32'h0000_0300, 32'h0, 0, 0);
        chk("R2 R3 addr reg sub", c_addr, regs[4] - 32'h300);
        chk("R4 base write val", c_bval, regs[4] - 32'h300);
        chk("R4 base en/idx", {27'd0, c_ben, c_bidx}, {27'd0, 1'b1, 4'd4});
        chk("R7 word store data", c_wdata, regs[6]);
        chk("R7 store flags", {30'd0, c_we, c_byte}, 32'b10);
        chk("R1 store no data write", 32'(c_den), 0);
        chk("R10 store cost", {23'd0, c_s, c_i, c_n}, {23'd0, 3'd0, 3'd0, 3'd2});
    endtask

    task automatic t_pre_pc_base;
        run_op(mk(1, 1, 0, 0, 1, 0, 15, 3, 12'h010), 32'h0, 32'h55, 0, 0);
        chk("R4 pc base +8", c_addr, 32'h0000_4018);
        chk("R4 pc base no write", 32'(c_ben), 0);
        run_op(mk(1, 0, 0, 1, 1, 0, 15, 3, 12'h010), 32'h0, 32'h55, 0, 0);
        chk("R3 pc base masked W=1", c_addr, 32'h0000_3FF0);
    endtask

    task automatic t_post_byte_load;
        run_op(mk(0, 0, 1, 0, 1, 0, 4, 5, 12'h020), 32'h0, 32'hFFFF_FF9C, 0, 0);
        chk("R5 post addr", c_addr, regs[4]);
        chk("R5 post base sub", c_bval, regs[4] - 32'h20);
        chk("R5 post base en", 32'(c_ben), 1);
        chk("R7 byte zero-ext", c_dval, 32'h0000_009C);
    endtask

    task automatic t_post_pc_store;
        run_op(mk(0, 1, 0, 0, 0, 0, 15, 1, 12'h020), 32'h0, 32'h0, 0, 0);
        chk("R5 post pc addr", c_addr, 32'h0000_4008);
        chk("R5 post pc base", c_bval, 32'h0000_4028);
        chk("R5 post pc idx", 32'(c_bidx), 15);
    endtask

    task automatic t_conflict;
        run_op(mk(0, 1, 0, 0, 1, 0, 7, 7, 12'h040), 32'h0, 32'hCAFE_0001, 0, 0);
        chk("R6 post load data wins", c_dval, 32'hCAFE_0001);
        chk("R6 post load base dropped", {30'd0, c_den, c_ben}, 32'b10);
        run_op(mk(1, 1, 0, 1, 1, 0, 7, 7, 12'h040), 32'h0, 32'hCAFE_0002, 0, 0);
        chk("R6 pre W load base dropped", {30'd0, c_den, c_ben}, 32'b10);
        run_op(mk(0, 0, 0, 0, 0, 0, 7, 7, 12'h040), 32'h0, 32'h0, 0, 0);
        chk("R6 post store no writes", {30'd0, c_den, c_ben}, 32'b00);
    endtask

    task automatic t_byte_store;
        run_op(mk(1, 1, 1, 0, 0, 0, 2, 9, 12'h001), 32'h0, 32'h0, 0, 0);
        chk("R7 byte store data", c_wdata, 32'h0000_00A9);
        chk("R7 byte store flags", {30'd0, c_we, c_byte}, 32'b11);
    endtask

    task automatic t_pc_store;
        run_op(mk(1, 1, 0, 0, 0, 0, 2, 15, 12'h000), 32'h0, 32'h0, 0, 0);
        chk("R8 pc store +8", c_wdata, 32'hA800_400B);
    endtask

    task automatic t_pc_load;
        run_op(mk(1, 1, 0, 0, 1, 0, 2, 15, 12'h000), 32'h0, 32'h0000_1000, 0, 0);
        chk("R9 pc load aligned -4", c_dval, 32'hA800_0FFF);
        chk("R10 pc load cost", {23'd0, c_s, c_i, c_n}, {23'd0, 3'd2, 3'd1, 3'd2});
        run_op(mk(1, 1, 0, 0, 1, 0, 2, 15, 12'h000), 32'h0, 32'h0000_2002, 0, 0);
        chk("R9 pc load unaligned", c_dval, 32'hA800_2003);
        run_op(mk(1, 1, 1, 0, 1, 0, 2, 15, 12'h000), 32'h0, 32'h0000_2002, 0, 0);
        chk("R10 byte pc load cost", {23'd0, c_s, c_i, c_n}, {23'd0, 3'd1, 3'd1, 3'd1});
    endtask

    task automatic t_stall_and_busy;
        run_op(mk(1, 1, 0, 0, 1, 0, 2, 3, 12'h008), 32'h0, 32'h7777_0000, 3, 1);
        chk("R11 valid held", 32'(c_valid_held), 1);
        chk("R11 addr stable", c_addr, c_addr0);
        chk("R12 start ignored addr", c_addr, regs[2] + 32'h8);
        chk("R12 start ignored dir", 32'(c_we), 0);
        chk("R12 start ignored wb", {27'd0, c_den, c_didx}, {27'd0, 1'b1, 4'd3});
        chk("R12 start ignored base", 32'(c_ben), 0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) regs[k] = 32'h1000_0000 + 32'(k) * 32'h100 + 32'(k);
        regs[9]  = 32'h1234_56A9;
        regs[15] = 32'hA800_4003;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pre_imm_load();
        t_pre_reg_store_wb();
        t_pre_pc_base();
        t_post_byte_load();
        t_post_pc_store();
        t_conflict();
        t_byte_store();
        t_pc_store();
        t_pc_load();
        t_stall_and_busy();
        repeat (2) @(negedge clk);
        chk("R1 idle at end", 32'(idle), 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule